// File: doc/BRIEF.md
# Serial-Bus Byte-Programmable Memory Target

This block is the target side of a small nonvolatile byte memory reached over a four-wire serial bus (active-low select, serial clock, data in, data out). It oversamples the bus on its own system clock, decodes 8-bit commands for array read, single-byte program, program enable and status read, and drives the data-out line together with an output-enable, so that the pad can be tri-stated whenever the target is not talking.

Programming is guarded in three ways. It needs an enable latch that is armed by a clean enable-only frame. It starts only when select is released after a complete program frame. It is refused for addresses inside the region chosen by a two-bit protection level. An accepted program runs for a fixed, parameterised number of system cycles. While that cycle runs, only status reads are answered. Reads stream bytes from an incrementing address that wraps around the end of the modelled array.

Top module: `spi_nvm_slave`

## Requirements
- R1: After reset the enable latch is clear, nothing is busy, the output-enable is low and the status byte reads {4'b0, prot_level, 1'b0, 1'b0}.
- R2: A program frame (opcode 8'h02) issued while the enable latch is clear leaves the array unchanged.
- R3: The enable opcode 8'h06 sets the latch only when select rises directly after exactly those 8 bits. Any further clock in that frame voids it, so a program command in the same frame has no effect.
- R4: A program frame is opcode, 16-bit address and data byte, each sent MSB first. Only the low ADDR_W address bits select a byte, and the upper bits are ignored.
- R5: Programming starts on the select rise that follows the data byte. Status bit 0 (busy) is high for PROG_CYCLES cycles and the byte is then stored. Busy and the latch (status bit 1) clear together when it completes.
- R6: While busy, every opcode other than status read is ignored, and the output stays disabled for it.
- R7: With prot_level 1, 2 or 3, the top quarter, the top half or the whole array respectively is protected. A program to a protected byte is refused and clears the latch.
- R8: A read (opcode 8'h03) keeps the output disabled during the opcode and address. It then returns bytes MSB first from successive addresses, wrapping from the last byte to byte 0.
- R9: A status read (opcode 8'h05) returns {4'b0, prot_level, latch, busy} MSB first and repeats it, refreshed, for as long as select stays low.
- R10: Clock mode 0 (idle low) and mode 3 (idle high) both work. Input is taken on the rising clock edge and the output changes on the falling edge.
- R11: Releasing select before a frame is complete discards it, leaving the array and the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low target select |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data into the target |
| prot_level | input | 2 | Protection level, 0 = none, 3 = whole array |
| miso | output | 1 | Serial data out of the target |
| miso_oe | output | 1 | High when miso should be driven |

## Verification
The bench builds the block with ADDR_W = 6 and PROG_CYCLES = 1500. The 64-byte array makes the wrap from byte 63 to byte 0 and every protection boundary (48, 32, 0) reachable in a few frames. The long program time leaves room to issue a status read and then a full read frame while the program cycle is still running. Random program and read-back frames mix both clock modes and addresses with non-zero upper bits.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;
    localparam logic [7:0] OPC_READ  = 8'h03;
    localparam logic [7:0] OPC_WRITE = 8'h02;
    localparam logic [7:0] OPC_STAT  = 8'h05;
    localparam logic [7:0] OPC_ARM   = 8'h06;

    typedef enum logic [3:0] {
        PH_IDLE, PH_OPC, PH_ARMED, PH_ADDR, PH_WDATA,
        PH_WFULL, PH_RDATA, PH_STAT, PH_SKIP
    } phase_e;
endpackage

// File: rtl/spi_nvm_insync.sv
module spi_nvm_insync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic cs_low,
    output logic cs_fall,
    output logic cs_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    logic [2:0] cs_q, cs_d;
    logic [2:0] sck_q, sck_d;
    logic [1:0] mosi_q, mosi_d;

    always_comb begin
        cs_d   = {cs_q[1:0], cs_n};
        sck_d  = {sck_q[1:0], sck};
        mosi_d = {mosi_q[0], mosi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 3'b111;
            sck_q  <= 3'b000;
            mosi_q <= 2'b00;
        end else begin
            cs_q   <= cs_d;
            sck_q  <= sck_d;
            mosi_q <= mosi_d;
        end
    end

    assign cs_low   = ~cs_q[1];
    assign cs_fall  = ~cs_q[1] &  cs_q[2];
    assign cs_rise  =  cs_q[1] & ~cs_q[2];
    assign sck_rise =  sck_q[1] & ~sck_q[2];
    assign sck_fall = ~sck_q[1] &  sck_q[2];
    assign mosi_s   = mosi_q[1];
endmodule

// File: rtl/spi_nvm_bytearray.sv
module spi_nvm_bytearray #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/spi_nvm_progtimer.sv
module spi_nvm_progtimer #(
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES);
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start)            cnt_d = LOAD;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R6
endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave
    import spi_nvm_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int PROG_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic [1:0] prot_level,
    output logic       miso,
    output logic       miso_oe
);
    typedef struct packed {
        phase_e            ph;
        logic [3:0]        cnt;
        logic [7:0]        opc;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdat;
        logic [7:0]        tx;
        logic [2:0]        rcnt;
        logic              sdo;
        logic              wel;
        logic [ADDR_W-1:0] paddr;
        logic [7:0]        pdat;
    } ctl_t;

    ctl_t st_q, st_d;

    logic cs_low, cs_fall, cs_rise, sck_rise, sck_fall, mosi_s;
    logic busy, tmr_done, start;
    logic [ADDR_W-1:0] raddr, addr_shift;
    logic [7:0] rdata, status;
    logic [7:0] opc_full;
    logic prot_hit;

    spi_nvm_insync i_sync (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
    );

    spi_nvm_progtimer #(.PROG_CYCLES(PROG_CYCLES)) i_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(tmr_done)
    );

    spi_nvm_bytearray #(.ADDR_W(ADDR_W), .DATA_W(8)) i_arr (
        .clk(clk), .rst_n(rst_n), .we(tmr_done), .waddr(st_q.paddr),
        .wdata(st_q.pdat), .raddr(raddr), .rdata(rdata)
    );

    // Protected region: level 1 top quarter, 2 top half, 3 everything.
    always_comb begin
        unique case (prot_level)
            2'd0:    prot_hit = 1'b0;
            2'd1:    prot_hit = &st_q.addr[ADDR_W-1 -: 2];
            2'd2:    prot_hit = st_q.addr[ADDR_W-1];
            default: prot_hit = 1'b1;
        endcase
    end

    assign status     = {4'b0000, prot_level, st_q.wel, busy};
    assign addr_shift = {st_q.addr[ADDR_W-2:0], mosi_s};
    assign opc_full   = {st_q.opc[6:0], mosi_s};
    assign raddr      = (st_q.ph == PH_ADDR) ? addr_shift : st_q.addr + 1'b1;

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (cs_fall) begin
            st_d.ph  = PH_OPC;
            st_d.cnt = '0;
        end else if (cs_rise) begin
            if (st_q.ph == PH_ARMED) begin
                st_d.wel = 1'b1;
            end else if (st_q.ph == PH_WFULL && st_q.wel) begin
                if (prot_hit) begin
                    st_d.wel = 1'b0;
                end else begin
                    start      = 1'b1;
                    st_d.paddr = st_q.addr;
                    st_d.pdat  = st_q.wdat;
                end
            end
            st_d.ph = PH_IDLE;
        end else if (cs_low && sck_rise) begin
            unique case (st_q.ph)
                PH_OPC: begin
                    st_d.opc = opc_full;
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == 4'd7) begin
                        st_d.cnt  = '0;
                        st_d.rcnt = '0;
                        if (busy && opc_full != OPC_STAT) st_d.ph = PH_SKIP;
                        else begin
                            unique case (opc_full)
                                OPC_STAT:  begin st_d.ph = PH_STAT; st_d.tx = status; end
                                OPC_READ:  st_d.ph = PH_ADDR;
                                OPC_WRITE: st_d.ph = PH_ADDR;
                                OPC_ARM:   st_d.ph = PH_ARMED;
                                default:   st_d.ph = PH_SKIP;
                            endcase
                        end
                    end
                end
                PH_ARMED: st_d.ph = PH_SKIP;
                PH_ADDR: begin
                    st_d.addr = addr_shift;
                    st_d.cnt  = st_q.cnt + 1'b1;
                    if (st_q.cnt == 4'd15) begin
                        st_d.cnt = '0;
                        if (st_q.opc == OPC_READ) begin
                            st_d.ph = PH_RDATA;
                            st_d.tx = rdata;
                        end else begin
                            st_d.ph = PH_WDATA;
                        end
                    end
                end
                PH_WDATA: begin
                    st_d.wdat = {st_q.wdat[6:0], mosi_s};
                    st_d.cnt  = st_q.cnt + 1'b1;
                    if (st_q.cnt == 4'd7) st_d.ph = PH_WFULL;
                end
                PH_RDATA: begin
                    st_d.rcnt = st_q.rcnt + 1'b1;
                    if (st_q.rcnt == 3'd7) begin
                        st_d.addr = st_q.addr + 1'b1;
                        st_d.tx   = rdata;
                    end
                end
                PH_STAT: begin
                    st_d.rcnt = st_q.rcnt + 1'b1;
                    if (st_q.rcnt == 3'd7) st_d.tx = status;
                end
                default: ;
            endcase
        end else if (cs_low && sck_fall &&
                     (st_q.ph == PH_RDATA || st_q.ph == PH_STAT)) begin
            st_d.sdo = st_q.tx[3'd7 - st_q.rcnt];
        end
        if (tmr_done) st_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso    = st_q.sdo;
    assign miso_oe = cs_low && (st_q.ph == PH_RDATA || st_q.ph == PH_STAT);

    AST_START_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> st_q.wel); // R2
    AST_LATCH_ARMS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.wel) |-> $past(cs_rise)); // R3
    AST_DONE_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |=> !st_q.wel); // R5
    AST_STORE_ONLY_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |-> $past(busy)); // R5
    AST_NO_OUTPUT_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !miso_oe); // R8
endmodule

// File: tb/test_spi_nvm_slave.sv
module test_spi_nvm_slave;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PROG   = 1500;
    localparam int H      = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic [1:0] prot_level = 2'd0;
    logic miso, miso_oe;

    always #4 clk = ~clk;

    spi_nvm_slave #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG)) i_spi_nvm_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .prot_level(prot_level), .miso(miso), .miso_oe(miso_oe)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    bit mode3 = 0;
    bit oe_any = 0;
    logic [7:0] model [DEPTH];
    logic model_wel = 0;
    logic [7:0] rbuf [8];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic wel, input logic bsy);
        return {4'b0000, prot_level, wel, bsy};
    endfunction

    function automatic bit is_prot(input int a);
        case (prot_level)
            2'd0: return 0;
            2'd1: return a >= (DEPTH * 3) / 4;
            2'd2: return a >= DEPTH / 2;
            default: return 1;
        endcase
    endfunction

    task automatic sel();
        sck = mode3;
        repeat (H) @(negedge clk);
        cs_n = 1'b0;
        oe_any = 0;
        repeat (H) @(negedge clk);
    endtask

    task automatic desel();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (3 * H) @(negedge clk);
        sck = mode3;
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i >= 8 - n; i--) begin
            if (mode3) sck = 1'b0;
            mosi = tx[i];
            repeat (H) @(negedge clk);
            rx[i] = miso;
            oe_any |= miso_oe;
            sck = 1'b1;
            repeat (H) @(negedge clk);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    task automatic do_arm();
        logic [7:0] d;
        sel(); xbyte(8'h06, d); desel();
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        sel(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d); xbyte(v, d); desel();
    endtask

    task automatic do_read(input logic [15:0] a, input int n, output bit hdr_oe);
        logic [7:0] d;
        sel(); xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
        hdr_oe = oe_any;
        for (int k = 0; k < n; k++) xbyte(8'h00, rbuf[k]);
        desel();
    endtask

    task automatic do_stat(input int n);
        logic [7:0] d;
        sel(); xbyte(8'h05, d);
        for (int k = 0; k < n; k++) xbyte(8'h00, rbuf[k]);
        desel();
    endtask

    task automatic wait_prog();
        repeat (PROG + 40) @(negedge clk);
    endtask

    // Full program sequence with model update; returns nothing, checks via read-back later.
    task automatic model_write(input logic [15:0] a, input logic [7:0] v);
        int idx;
        idx = int'(a[ADDR_W-1:0]);
        do_write(a, v);
        if (model_wel) begin
            if (!is_prot(idx)) model[idx] = v;
            model_wel = 0;
        end
        wait_prog();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit h;
        logic [7:0] d;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        check("R1 oe after reset", miso_oe, 0);
        do_stat(1);
        check("R1 status after reset", rbuf[0], exp_status(0, 0));

        // R2 program without the latch
        model_write(16'h0005, 8'hA5);
        do_read(16'h0005, 1, h);
        check("R2 no write without latch", rbuf[0], model[5]);

        // R3 enable and program in one frame
        sel(); xbyte(8'h06, d); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h05, d); xbyte(8'h77, d); desel();
        do_stat(1);
        check("R3 latch voided by extra bits", rbuf[0], exp_status(0, 0));
        wait_prog();
        do_read(16'h0005, 1, h);
        check("R3 same-frame write ignored", rbuf[0], 8'hFF);

        // R3 arm, R5 busy, R6 ignored read, R4 address aliasing
        do_arm(); model_wel = 1;
        do_stat(1);
        check("R3 latch armed", rbuf[0], exp_status(1, 0));
        do_write(16'hFFC5, 8'h3C);
        do_stat(2);
        check("R5 busy with latch", rbuf[0], exp_status(1, 1));
        check("R9 status repeats", rbuf[1], exp_status(1, 1));
        do_read(16'h0005, 1, h);
        check("R6 read ignored while busy", {31'd0, oe_any}, 0);
        wait_prog();
        model[5] = 8'h3C; model_wel = 0;
        do_stat(1);
        check("R5 busy and latch clear", rbuf[0], exp_status(0, 0));
        do_read(16'h0005, 1, h);
        check("R4 upper address bits ignored", rbuf[0], 8'h3C);
        check("R8 output off during header", {31'd0, h}, 0);

        // R7 protection boundaries
        prot_level = 2'd1;
        do_arm(); model_wel = 1;
        do_write(16'd48, 8'h11);
        do_stat(1);
        check("R7 rejected clears latch lvl1", rbuf[0], exp_status(0, 0));
        model_wel = 0;
        wait_prog();
        do_arm(); model_wel = 1; model_write(16'd47, 8'h22);
        prot_level = 2'd2;
        do_arm(); model_wel = 1; model_write(16'd32, 8'h33);
        do_arm(); model_wel = 1; model_write(16'd31, 8'h44);
        prot_level = 2'd3;
        do_arm(); model_wel = 1; model_write(16'd0, 8'h55);
        prot_level = 2'd0;
        do_read(16'd48, 1, h); check("R7 lvl1 boundary refused", rbuf[0], model[48]);
        do_read(16'd47, 1, h); check("R7 lvl1 below boundary stored", rbuf[0], 8'h22);
        do_read(16'd32, 1, h); check("R7 lvl2 boundary refused", rbuf[0], 8'hFF);
        do_read(16'd31, 1, h); check("R7 lvl2 below boundary stored", rbuf[0], 8'h44);
        do_read(16'd0, 1, h);  check("R7 lvl3 refused", rbuf[0], 8'hFF);

        // R11 abort mid data byte
        do_arm(); model_wel = 1;
        sel(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h09, d); xbits(8'hC3, 4, d); desel();
        do_stat(1);
        check("R11 latch kept after abort", rbuf[0], exp_status(1, 0));
        do_read(16'h0009, 1, h);
        check("R11 array unchanged after abort", rbuf[0], model[9]);

        // R10 mode 3 program and read
        mode3 = 1;
        model_write(16'h003E, 8'hE1);
        do_arm(); model_wel = 1; model_write(16'h003F, 8'hF2);
        do_arm(); model_wel = 1; model_write(16'h0000, 8'h0A);
        // R8 streaming with wrap
        do_read(16'h003E, 4, h);
        check("R10 mode3 read", rbuf[0], 8'hE1);
        check("R8 stream second", rbuf[1], 8'hF2);
        check("R8 stream wrap", rbuf[2], 8'h0A);
        check("R8 stream after wrap", rbuf[3], model[1]);
        mode3 = 0;

        // Random program and read-back, mixed modes
        for (int it = 0; it < 24; it++) begin
            logic [15:0] a;
            logic [7:0] v;
            a = 16'($urandom);
            v = 8'($urandom);
            mode3 = $urandom % 2;
            do_arm(); model_wel = 1;
            model_write(a, v);
            mode3 = $urandom % 2;
            do_read(a, 2, h);
            check("R4 random read-back", rbuf[0], model[int'(a[ADDR_W-1:0])]);
            check("R10 random next byte", rbuf[1], model[int'(a[ADDR_W-1:0] + 1'b1)]);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule